// File: doc/BRIEF.md
# Block-Reseeded Test Pattern Source and Checker

This block is the data path of a storage-bus test adapter. Once a transfer starts, it walks a run of logical blocks. For each byte position it forms an expected byte from one of two sources: a buffer read port, or a 32-bit pseudo-random generator. It then replaces four bytes at a programmable position in every block with that block's logical block address (LBA). In write mode the expected stream leaves the block on a valid/ready byte output. In read mode a received byte stream is compared against the expected bytes at one byte per cycle, and mismatches are recorded.

The generator is reloaded at every block boundary from a seed built only from the configured base seed and the current LBA. Any block can therefore be regenerated on its own, without stepping through earlier blocks. This lets a sequential write be read back block by block in any order. The first mismatch is held with its location and both byte values, and a saturating counter keeps the total.

Top module: `blkpat_engine`

## Requirements
- R1: After reset, `busy`, `gen_valid`, `rx_ready`, `cfg_err` and `mis_flag` are 0 and `err_cnt` is 0.
- R2: A `start` pulse with `cfg_blk_cnt` equal to 0, or with `cfg_ovl_off + 4 > cfg_blk_len`, sets `cfg_err` and leaves `busy` at 0. A legal `start` clears `cfg_err` and raises `busy` on the next cycle.
- R3: At the first byte of each block the generator state is loaded with `cfg_seed XOR lba`, and an all-zero result is replaced by 32'h00000001. Each beat emits `state[7:0]`, then advances the state by 8 right-shift Galois steps: shift right by one and, if the bit shifted out was 1, XOR with 32'h80200003.
- R4: A block's generated bytes depend only on the seed and that block's LBA. A one-block transfer starting at LBA n yields the same bytes as block n of a longer transfer that starts earlier.
- R5: Byte offsets `cfg_ovl_off` to `cfg_ovl_off+3` of each block carry the block's LBA, most significant byte first, for either source. The generator still advances across these bytes.
- R6: With `cfg_src_buf` = 1, the non-overlay bytes are `buf_rdata` from the same cycle. `buf_addr` is the byte index since start (0-based, modulo 2^BUF_AW).
- R7: In write mode `gen_valid` is high while busy, and `rx_ready` is low. A beat is taken only when `gen_ready` is high. While stalled, `gen_data` holds.
- R8: The LBA rises by one at each block boundary, wrapping at 32 bits. `busy` falls after exactly `cfg_blk_len * cfg_blk_cnt` beats.
- R9: In read mode `rx_ready` stays high for the whole transfer and `gen_valid` stays low. Every received byte that differs from the expected byte adds one to `err_cnt`.
- R10: The first mismatch after start latches `mis_flag`, its LBA, byte offset, expected byte and received byte. Later mismatches do not change them.
- R11: `err_cnt` saturates at 2^ERR_W-1.
- R12: Any `start`, legal or not, clears `mis_flag` and `err_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer with the configuration below |
| cfg_blk_len | input | LEN_W | Bytes per block |
| cfg_blk_cnt | input | CNT_W | Blocks in the transfer |
| cfg_lba_base | input | 32 | LBA of the first block |
| cfg_seed | input | 32 | Base seed for the generator |
| cfg_ovl_off | input | LEN_W | Byte offset of the LBA overlay |
| cfg_src_buf | input | 1 | 1: buffer source, 0: generator |
| cfg_rd_mode | input | 1 | 1: compare received data, 0: emit stream |
| cfg_err | output | 1 | Last start had an illegal configuration |
| busy | output | 1 | Transfer in progress |
| buf_addr | output | BUF_AW | Buffer read address |
| buf_rdata | input | 8 | Buffer read data for `buf_addr` |
| gen_valid | output | 1 | Write stream byte valid |
| gen_ready | input | 1 | Write stream sink ready |
| gen_data | output | 8 | Write stream byte |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Block accepts received bytes |
| rx_data | input | 8 | Received byte |
| mis_flag | output | 1 | A mismatch has been latched |
| mis_lba | output | 32 | LBA of first mismatch |
| mis_off | output | LEN_W | Byte offset of first mismatch |
| mis_exp | output | 8 | Expected byte at first mismatch |
| mis_act | output | 8 | Received byte at first mismatch |
| err_cnt | output | ERR_W | Saturating mismatch count |

## Verification
The bench targets the places where a per-block reseed goes wrong. It uses an all-zero seed result, where a design missing the substitute would lock up and emit zeros. It uses an LBA that wraps past 32'hFFFFFFFF, where a narrow adder would corrupt the overlay or the next seed. It places the overlay at the first and the last legal offsets, where an off-by-one would shift or clip the address. It compares block n of a long write with a one-block write at LBA n; a generator that carries state across blocks would fail that match. On the read side it sends a second error after the first, where a design that overwrites the record would report the wrong location. It also drives more mismatches than the counter can hold, where a design without saturation would wrap. It issues starts with illegal configurations, to show they neither run nor keep old results.

// File: rtl/blkpat_pkg.sv
package blkpat_pkg;

  localparam logic [31:0] LFSR_MASK = 32'h80200003;
  localparam logic [31:0] SEED_SUBST = 32'h00000001;

  // one right-shift Galois step
  function automatic logic [31:0] lfsr_step1(input logic [31:0] s);
    logic [31:0] r;
    r = s >> 1;
    if (s[0]) r = r ^ LFSR_MASK;
    return r;
  endfunction

  // per-block seed: base seed mixed with the block address, zero avoided
  function automatic logic [31:0] blk_seed(input logic [31:0] seed, input logic [31:0] lba);
    logic [31:0] m;
    m = seed ^ lba;
    if (m == 32'h0) m = SEED_SUBST;
    return m;
  endfunction

endpackage

// File: rtl/blkpat_prng.sv
module blkpat_prng #(
  parameter int STEPS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] load_val,
  input  logic        adv,
  output logic [7:0]  byte_o
);
  import blkpat_pkg::*;

  logic [31:0] state_q, state_d;
  logic [31:0] chain [STEPS+1];

  assign chain[0] = state_q;
  for (genvar g = 0; g < STEPS; g++) begin : g_step
    assign chain[g+1] = lfsr_step1(chain[g]);
  end

  always_comb begin
    state_d = state_q;
    if (load)     state_d = load_val;
    else if (adv) state_d = chain[STEPS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            state_q <= SEED_SUBST;
    else if (load || adv)  state_q <= state_d;
  end

  assign byte_o = state_q[7:0];
endmodule

// File: rtl/blkpat_expect.sv
module blkpat_expect #(
  parameter int LEN_W = 12
) (
  input  logic [LEN_W-1:0] off,
  input  logic [LEN_W-1:0] ovl_off,
  input  logic [31:0]      lba,
  input  logic             src_buf,
  input  logic [7:0]       prng_byte,
  input  logic [7:0]       buf_byte,
  output logic [7:0]       exp_byte
);
  logic [LEN_W-1:0] diff;
  logic             in_ovl;
  logic [7:0]       ovl_b [4];

  for (genvar g = 0; g < 4; g++) begin : g_ovl
    assign ovl_b[g] = lba[31-8*g -: 8];
  end

  assign diff   = off - ovl_off;
  assign in_ovl = (off >= ovl_off) && (diff < LEN_W'(4));

  always_comb begin
    if (in_ovl)       exp_byte = ovl_b[diff[1:0]];
    else if (src_buf) exp_byte = buf_byte;
    else              exp_byte = prng_byte;
  end
endmodule

// File: rtl/blkpat_seq.sv
module blkpat_seq #(
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 16,
  parameter int BUF_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfg_blk_len,
  input  logic [CNT_W-1:0]  cfg_blk_cnt,
  input  logic [31:0]       cfg_lba_base,
  input  logic [31:0]       cfg_seed,
  input  logic [LEN_W-1:0]  cfg_ovl_off,
  input  logic              cfg_src_buf,
  input  logic              cfg_rd_mode,
  input  logic              beat,
  output logic              busy,
  output logic              cfg_err,
  output logic              rd_mode,
  output logic              src_buf,
  output logic [31:0]       lba,
  output logic [LEN_W-1:0]  off,
  output logic [LEN_W-1:0]  ovl_off,
  output logic [BUF_AW-1:0] buf_addr,
  output logic              prng_load,
  output logic [31:0]       prng_seed,
  output logic              prng_adv
);
  import blkpat_pkg::*;

  logic              busy_q, busy_d, err_q, err_d, rd_q, rd_d, src_q, src_d;
  logic [31:0]       lba_q, lba_d, seed_q, seed_d;
  logic [LEN_W-1:0]  off_q, off_d, len_q, len_d, ovl_q, ovl_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [BUF_AW-1:0] addr_q, addr_d;
  logic [LEN_W:0]    ovl_end;
  logic              legal, step, last_byte, upd;

  assign ovl_end   = {1'b0, cfg_ovl_off} + (LEN_W+1)'(4);
  assign legal     = (cfg_blk_cnt != '0) && (ovl_end <= {1'b0, cfg_blk_len});
  assign step      = busy_q && beat && !start;
  assign last_byte = (off_q == len_q - 1'b1);
  assign upd       = start || step;

  always_comb begin
    busy_d = busy_q; err_d = err_q; rd_d = rd_q; src_d = src_q;
    lba_d = lba_q; seed_d = seed_q; off_d = off_q; len_d = len_q;
    ovl_d = ovl_q; left_d = left_q; addr_d = addr_q;
    if (start) begin
      err_d  = !legal;
      busy_d = legal;
      if (legal) begin
        rd_d = cfg_rd_mode; src_d = cfg_src_buf;
        lba_d = cfg_lba_base; seed_d = cfg_seed;
        len_d = cfg_blk_len; ovl_d = cfg_ovl_off;
        left_d = cfg_blk_cnt; off_d = '0; addr_d = '0;
      end
    end else if (step) begin
      addr_d = addr_q + 1'b1;
      if (last_byte) begin
        off_d  = '0;
        lba_d  = lba_q + 32'd1;
        left_d = left_q - 1'b1;
        if (left_q == CNT_W'(1)) busy_d = 1'b0;
      end else begin
        off_d = off_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; err_q <= 1'b0; rd_q <= 1'b0; src_q <= 1'b0;
      lba_q <= '0; seed_q <= '0; off_q <= '0; len_q <= '0;
      ovl_q <= '0; left_q <= '0; addr_q <= '0;
    end else if (upd) begin
      busy_q <= busy_d; err_q <= err_d; rd_q <= rd_d; src_q <= src_d;
      lba_q <= lba_d; seed_q <= seed_d; off_q <= off_d; len_q <= len_d;
      ovl_q <= ovl_d; left_q <= left_d; addr_q <= addr_d;
    end
  end

  assign prng_load = (start && legal) || (step && last_byte);
  assign prng_seed = start ? blk_seed(cfg_seed, cfg_lba_base)
                           : blk_seed(seed_q, lba_q + 32'd1);
  assign prng_adv  = step;

  assign busy     = busy_q;
  assign cfg_err  = err_q;
  assign rd_mode  = rd_q;
  assign src_buf  = src_q;
  assign lba      = lba_q;
  assign off      = off_q;
  assign ovl_off  = ovl_q;
  assign buf_addr = addr_q;
endmodule

// File: rtl/blkpat_cmp.sv
module blkpat_cmp #(
  parameter int LEN_W = 12,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             chk_en,
  input  logic [7:0]       exp_byte,
  input  logic [7:0]       act_byte,
  input  logic [31:0]      lba,
  input  logic [LEN_W-1:0] off,
  output logic             mis_flag,
  output logic [31:0]      mis_lba,
  output logic [LEN_W-1:0] mis_off,
  output logic [7:0]       mis_exp,
  output logic [7:0]       mis_act,
  output logic [ERR_W-1:0] err_cnt
);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  logic             bad, cnt_en, rec_en, flag_d;
  logic [ERR_W-1:0] cnt_q, cnt_d;
  logic             flag_q;
  logic [31:0]      lba_q;
  logic [LEN_W-1:0] off_q;
  logic [7:0]       exp_q, act_q;

  assign bad    = chk_en && (exp_byte != act_byte);
  assign cnt_en = clr || (bad && cnt_q != CNT_MAX);
  assign rec_en = !clr && bad && !flag_q;

  always_comb begin
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
    flag_d = clr ? 1'b0 : (flag_q || bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_en)          cnt_q  <= cnt_d;
      if (clr || rec_en)   flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lba_q <= '0; off_q <= '0; exp_q <= '0; act_q <= '0;
    end else if (rec_en) begin
      lba_q <= lba; off_q <= off; exp_q <= exp_byte; act_q <= act_byte;
    end
  end

  assign mis_flag = flag_q;
  assign mis_lba  = lba_q;
  assign mis_off  = off_q;
  assign mis_exp  = exp_q;
  assign mis_act  = act_q;
  assign err_cnt  = cnt_q;
endmodule

// File: rtl/blkpat_engine.sv
module blkpat_engine #(
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 16,
  parameter int BUF_AW = 12,
  parameter int ERR_W  = 8,
  parameter int STEPS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfg_blk_len,
  input  logic [CNT_W-1:0]  cfg_blk_cnt,
  input  logic [31:0]       cfg_lba_base,
  input  logic [31:0]       cfg_seed,
  input  logic [LEN_W-1:0]  cfg_ovl_off,
  input  logic              cfg_src_buf,
  input  logic              cfg_rd_mode,
  output logic              cfg_err,
  output logic              busy,
  output logic [BUF_AW-1:0] buf_addr,
  input  logic [7:0]        buf_rdata,
  output logic              gen_valid,
  input  logic              gen_ready,
  output logic [7:0]        gen_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              mis_flag,
  output logic [31:0]       mis_lba,
  output logic [LEN_W-1:0]  mis_off,
  output logic [7:0]        mis_exp,
  output logic [7:0]        mis_act,
  output logic [ERR_W-1:0]  err_cnt
);
  logic             rd_mode, src_buf, beat, prng_load, prng_adv;
  logic [31:0]      lba, prng_seed;
  logic [LEN_W-1:0] off, ovl_off;
  logic [7:0]       prng_byte, exp_byte;

  assign beat      = busy && (rd_mode ? rx_valid : gen_ready);
  assign gen_valid = busy && !rd_mode;
  assign rx_ready  = busy && rd_mode;
  assign gen_data  = exp_byte;

  blkpat_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W), .BUF_AW(BUF_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_blk_len(cfg_blk_len), .cfg_blk_cnt(cfg_blk_cnt),
    .cfg_lba_base(cfg_lba_base), .cfg_seed(cfg_seed),
    .cfg_ovl_off(cfg_ovl_off), .cfg_src_buf(cfg_src_buf),
    .cfg_rd_mode(cfg_rd_mode), .beat(beat), .busy(busy),
    .cfg_err(cfg_err), .rd_mode(rd_mode), .src_buf(src_buf),
    .lba(lba), .off(off), .ovl_off(ovl_off), .buf_addr(buf_addr),
    .prng_load(prng_load), .prng_seed(prng_seed), .prng_adv(prng_adv)
  );

  blkpat_prng #(.STEPS(STEPS)) u_prng (
    .clk(clk), .rst_n(rst_n), .load(prng_load), .load_val(prng_seed),
    .adv(prng_adv), .byte_o(prng_byte)
  );

  blkpat_expect #(.LEN_W(LEN_W)) u_exp (
    .off(off), .ovl_off(ovl_off), .lba(lba), .src_buf(src_buf),
    .prng_byte(prng_byte), .buf_byte(buf_rdata), .exp_byte(exp_byte)
  );

  blkpat_cmp #(.LEN_W(LEN_W), .ERR_W(ERR_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .chk_en(busy && rd_mode && rx_valid && !start),
    .exp_byte(exp_byte), .act_byte(rx_data), .lba(lba), .off(off),
    .mis_flag(mis_flag), .mis_lba(mis_lba), .mis_off(mis_off),
    .mis_exp(mis_exp), .mis_act(mis_act), .err_cnt(err_cnt)
  );
endmodule

// File: rtl/blkpat_engine_chk.sv
module blkpat_engine_chk #(
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 16,
  parameter int BUF_AW = 12,
  parameter int ERR_W  = 8,
  parameter int STEPS  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [LEN_W-1:0]  cfg_blk_len,
  input logic [CNT_W-1:0]  cfg_blk_cnt,
  input logic [31:0]       cfg_lba_base,
  input logic [31:0]       cfg_seed,
  input logic [LEN_W-1:0]  cfg_ovl_off,
  input logic              cfg_src_buf,
  input logic              cfg_rd_mode,
  input logic              cfg_err,
  input logic              busy,
  input logic [BUF_AW-1:0] buf_addr,
  input logic [7:0]        buf_rdata,
  input logic              gen_valid,
  input logic              gen_ready,
  input logic [7:0]        gen_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [7:0]        rx_data,
  input logic              mis_flag,
  input logic [31:0]       mis_lba,
  input logic [LEN_W-1:0]  mis_off,
  input logic [7:0]        mis_exp,
  input logic [7:0]        mis_act,
  input logic [ERR_W-1:0]  err_cnt
);
  localparam logic [ERR_W-1:0] CMAX = '1;

  AST_ZERO_CNT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg_blk_cnt == '0) |=> (cfg_err && !busy)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_valid && !gen_ready && !start) |=> (gen_valid && $stable(gen_data))); // R7

  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gen_valid && rx_ready)); // R9

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && ((gen_valid && gen_ready) || (rx_ready && rx_valid)))
    |=> (buf_addr == BUF_AW'($past(buf_addr) + 1'b1))); // R6

  AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_flag && !start) |=> (mis_flag && $stable(mis_lba) && $stable(mis_off)
                               && $stable(mis_exp) && $stable(mis_act))); // R10

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == CMAX && !start) |=> (err_cnt == CMAX)); // R11

  AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (err_cnt >= $past(err_cnt))); // R11

  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!mis_flag && err_cnt == '0)); // R12
endmodule

bind blkpat_engine blkpat_engine_chk #(
  .LEN_W(LEN_W), .CNT_W(CNT_W), .BUF_AW(BUF_AW), .ERR_W(ERR_W), .STEPS(STEPS)
) u_chk (.*);

// File: tb/tb_blkpat_engine.sv
`timescale 1ns/1ps
module tb_blkpat_engine;
  localparam int LEN_W = 12, CNT_W = 16, BUF_AW = 12, ERR_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [LEN_W-1:0] cfg_blk_len, cfg_ovl_off;
  logic [CNT_W-1:0] cfg_blk_cnt;
  logic [31:0] cfg_lba_base, cfg_seed;
  logic cfg_src_buf, cfg_rd_mode, cfg_err, busy;
  logic [BUF_AW-1:0] buf_addr;
  logic [7:0] buf_rdata, gen_data, rx_data, mis_exp, mis_act;
  logic gen_valid, gen_ready, rx_valid, rx_ready, mis_flag;
  logic [31:0] mis_lba;
  logic [LEN_W-1:0] mis_off;
  logic [ERR_W-1:0] err_cnt;

  int checks = 0, failures = 0;
  logic [7:0] cap [0:1023];
  logic [7:0] saved [0:15];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] bufm(input int a);
    logic [11:0] a12;
    a12 = 12'(a);
    return 8'(a12 * 7) ^ 8'h3C;
  endfunction

  assign buf_rdata = bufm(int'(buf_addr));

  blkpat_engine dut (.*);

  function automatic logic [31:0] m_step8(input logic [31:0] s);
    logic [31:0] r;
    r = s;
    for (int i = 0; i < 8; i++) begin
      if (r[0]) r = (r >> 1) ^ 32'h80200003;
      else      r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] m_exp(input int len, input int ovl, input logic [31:0] base,
                                       input logic [31:0] seed, input bit src, input int k);
    int blk, off;
    logic [31:0] lba, s;
    blk = k / len; off = k % len;
    lba = base + 32'(blk);
    if (off >= ovl && off < ovl + 4) return 8'(lba >> (8 * (3 - (off - ovl))));
    if (src) return bufm(k % 4096);
    s = seed ^ lba;
    if (s == 32'h0) s = 32'h1;
    for (int i = 0; i < off; i++) s = m_step8(s);
    return s[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input int len, input int ovl, input logic [31:0] base,
                          input logic [31:0] seed, input int nblk, input bit src, input bit rd);
    @(negedge clk);
    cfg_blk_len = LEN_W'(len); cfg_ovl_off = LEN_W'(ovl); cfg_lba_base = base;
    cfg_seed = seed; cfg_blk_cnt = CNT_W'(nblk); cfg_src_buf = src; cfg_rd_mode = rd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
  endtask

  task automatic run(input int len, input int ovl, input logic [31:0] base, input logic [31:0] seed,
                     input int nblk, input bit src, input bit rd, input int err_at, input bit all_bad);
    int total, k, cyc, first_err, nerr, off;
    logic [7:0] e, held;
    bit hold_chk, bad;
    string tag;
    total = len * nblk; k = 0; cyc = 0; first_err = -1; nerr = 0; hold_chk = 0;
    do_start(len, ovl, base, seed, nblk, src, rd);
    chk(busy && !cfg_err, "R2 legal start", {busy, cfg_err}, 2'b10);
    chk(err_cnt == 0 && !mis_flag, "R12 cleared at start", err_cnt, 0);
    while (k < total && cyc < 20000) begin
      e = m_exp(len, ovl, base, seed, src, k);
      bad = rd && (all_bad || k == err_at || k == err_at + 5);
      if (!rd) gen_ready = (cyc % 3 != 1);
      else begin
        rx_valid = (cyc % 4 != 2);
        rx_data = bad ? (e ^ 8'h10) : e;
      end
      #1;
      if (!rd) begin
        chk(gen_valid && !rx_ready, "R7 write handshake", {gen_valid, rx_ready}, 2'b10);
        if (hold_chk) chk(gen_data == held, "R7 stall hold", gen_data, held);
        if (gen_ready) begin
          off = k % len;
          tag = (off >= ovl && off < ovl + 4) ? "R5 overlay" : (src ? "R6 buffer byte" : "R3 prng byte");
          chk(gen_data == e, tag, gen_data, e);
          if (src) chk(buf_addr == BUF_AW'(k), "R6 buf_addr", buf_addr, k);
          cap[k] = gen_data;
          k++;
          hold_chk = 0;
        end else begin
          held = gen_data;
          hold_chk = 1;
        end
      end else begin
        chk(rx_ready && !gen_valid, "R9 no stall", {rx_ready, gen_valid}, 2'b10);
        if (rx_valid) begin
          if (bad) begin
            nerr++;
            if (first_err < 0) first_err = k;
          end
          k++;
        end
      end
      cyc++;
      @(negedge clk);
    end
    gen_ready = 1'b0; rx_valid = 1'b0;
    #1;
    chk(k == total && !busy, "R8 ends after len*cnt beats", {31'(k), busy}, {31'(total), 1'b0});
    if (rd) begin
      chk(err_cnt == ERR_W'(nerr > 255 ? 255 : nerr), "R9/R11 err_cnt", err_cnt, nerr);
      if (first_err >= 0) begin
        e = m_exp(len, ovl, base, seed, src, first_err);
        chk(mis_flag, "R10 flag", mis_flag, 1);
        chk(mis_lba == base + 32'(first_err / len), "R10 lba", mis_lba, base + 32'(first_err / len));
        chk(mis_off == LEN_W'(first_err % len), "R10 offset", mis_off, first_err % len);
        chk(mis_exp == e && mis_act == (e ^ 8'h10), "R10 bytes", {mis_exp, mis_act}, {e, e ^ 8'h10});
      end else begin
        chk(!mis_flag, "R9 no mismatch", mis_flag, 0);
      end
    end
  endtask

  typedef struct packed {
    logic [11:0] len;
    logic [11:0] ovl;
    logic [31:0] base;
    logic [31:0] seed;
    logic [7:0]  nblk;
    logic        src;
    logic        rd;
    logic [7:0]  err_at;
  } vec_t;

  localparam vec_t VT [0:5] = '{
    '{12'd16, 12'd0,  32'h00000100, 32'hDEADBEEF, 8'd3, 1'b0, 1'b0, 8'hFF},
    '{12'd20, 12'd16, 32'hFFFFFFFE, 32'h12345678, 8'd3, 1'b0, 1'b0, 8'hFF},
    '{12'd8,  12'd3,  32'h00000007, 32'h00000007, 8'd2, 1'b0, 1'b0, 8'hFF},
    '{12'd12, 12'd5,  32'h0A0B0C0D, 32'h00000001, 8'd2, 1'b1, 1'b0, 8'hFF},
    '{12'd16, 12'd2,  32'h00000028, 32'hCAFEF00D, 8'd3, 1'b0, 1'b1, 8'd21},
    '{12'd10, 12'd6,  32'h00000003, 32'h00000055, 8'd2, 1'b1, 1'b1, 8'hFF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; gen_ready = 1'b0; rx_valid = 1'b0; rx_data = 8'h0;
    cfg_blk_len = '0; cfg_ovl_off = '0; cfg_blk_cnt = '0; cfg_lba_base = '0;
    cfg_seed = '0; cfg_src_buf = 1'b0; cfg_rd_mode = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !gen_valid && !rx_ready && !cfg_err && !mis_flag && err_cnt == 0,
        "R1 reset state", {busy, gen_valid, rx_ready, cfg_err, mis_flag}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++) begin
      run(int'(VT[i].len), int'(VT[i].ovl), VT[i].base, VT[i].seed, int'(VT[i].nblk),
          VT[i].src, VT[i].rd, (VT[i].err_at == 8'hFF) ? -100 : int'(VT[i].err_at), 1'b0);
    end

    // R4: block at LBA 12 regenerated alone matches the third block of a longer run
    run(16, 0, 32'd10, 32'h0BADF00D, 3, 1'b0, 1'b0, -100, 1'b0);
    for (int i = 0; i < 16; i++) saved[i] = cap[32 + i];
    run(16, 0, 32'd12, 32'h0BADF00D, 1, 1'b0, 1'b0, -100, 1'b0);
    for (int i = 0; i < 16; i++)
      chk(cap[i] == saved[i], "R4 standalone block", cap[i], saved[i]);

    // R11: more mismatches than the counter holds
    run(64, 0, 32'h200, 32'h600DCAFE, 5, 1'b0, 1'b1, -100, 1'b1);

    // R2 + R12: illegal starts stay idle and still clear results
    do_start(16, 0, 32'h0, 32'h1, 0, 1'b0, 1'b1);
    chk(cfg_err && !busy, "R2 zero block count", {cfg_err, busy}, 2'b10);
    chk(!mis_flag && err_cnt == 0, "R12 cleared by illegal start", err_cnt, 0);
    do_start(16, 13, 32'h0, 32'h1, 1, 1'b0, 1'b0);
    chk(cfg_err && !busy && !gen_valid, "R2 overlay past block end", {cfg_err, busy}, 2'b10);
    do_start(16, 12, 32'h0, 32'h1, 1, 1'b0, 1'b0);
    chk(!cfg_err && busy, "R2 overlay at last legal offset", {cfg_err, busy}, 2'b01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule